// File: doc/BRIEF.md
# UART Loopback and Modem-Line Router

This block sits between one UART channel's serial engine and its package pins. In normal mode the transmitter's serial output goes out on the TX pin, and the RX pin feeds the receiver. The RTS and DTR pins follow their bits in the modem control word. The four external modem inputs (CTS, DSR, RI, CD) feed the modem-status register.

In loopback mode the pins are isolated. The TX pin idles high, RTS and DTR are driven inactive (low), and the RX pin is ignored. The transmitter output is wired straight to the receiver input, so a character written to the transmit holding register comes back as received data. The four low control bits stand in for the modem inputs through a fixed cross-map.

The mode is held in a two-state machine. In state `LB_NORMAL`, the transition `enter_loop` is taken at a clock edge that sees control bit 4 high. In state `LB_LOOP`, the transition `leave_loop` is taken at an edge that sees it low. Otherwise the machine stays where it is. All routing muxes are steered only by this state register, so a mode change happens cleanly at one edge.

The status register holds the current level of each modem line (bits 7:4) and a sticky change flag per line (bits 3:0). The flags are cleared by a read strobe.

Top module: `lpbk_modem_router`

## Requirements
- R1: While reset is asserted, and until the first edge that sees control bit 4 high, the mode is normal. During reset `msr_q` is 0x00.
- R2: In normal mode `pin_tx` equals `tx_ser_in` and `rx_ser_out` equals `pin_rx`, with no register in the path.
- R3: In normal mode `pin_rts` equals control bit 1 and `pin_dtr` equals control bit 0.
- R4: The mode register takes the value of control bit 4 at each rising edge, and the routing changes only after that edge.
- R5: In loopback mode `pin_tx` is 1, `rx_ser_out` equals `tx_ser_in`, and `pin_rx` has no effect on any output.
- R6: In loopback mode `pin_rts` and `pin_dtr` are 0.
- R7: `msr_q` bit 4 is CTS, bit 5 is DSR, bit 6 is RI and bit 7 is CD. At each edge they capture the selected sources. In normal mode the sources are the `pin_cts`, `pin_dsr`, `pin_ri` and `pin_cd` inputs.
- R8: In loopback mode the sources are control bits: bit 1 gives CTS, bit 0 gives DSR, bit 2 gives RI and bit 3 gives CD. The external modem pins have no effect.
- R9: Flag bits 0 (CTS), 1 (DSR) and 3 (CD) set when the captured level changes in either direction. Bit 2 (RI) sets only when RI goes from 1 to 0. A flag stays set until cleared.
- R10: An edge that sees `msr_rd` high clears all flags. A change detected at that same edge still sets its own flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mcr_bits | input | 5 | Modem control word: 0 DTR, 1 RTS, 2 OP1, 3 OP2, 4 loopback |
| tx_ser_in | input | 1 | Serial output of the transmitter |
| rx_ser_out | output | 1 | Serial input delivered to the receiver |
| pin_tx | output | 1 | TX pin |
| pin_rx | input | 1 | RX pin |
| pin_cts | input | 1 | External CTS, active high |
| pin_dsr | input | 1 | External DSR, active high |
| pin_ri | input | 1 | External RI, active high |
| pin_cd | input | 1 | External CD, active high |
| pin_rts | output | 1 | RTS pin, active high |
| pin_dtr | output | 1 | DTR pin, active high |
| msr_rd | input | 1 | One-cycle read strobe of the status register |
| msr_q | output | 8 | Status register: line levels in 7:4, change flags in 3:0 |

## Verification
The properties assume that every input is synchronous to `clk` and settled at each rising edge. They also assume that `msr_rd` is a strobe sampled at that edge, not a level read back at some other time. The stimulus meets these assumptions by changing the control word, the serial lines, the modem pins and the read strobe only a short time after a rising edge. Every value is therefore held for the whole of the following cycle. The scenarios toggle modem lines both singly and together, in both modes. They also place a read strobe in the same cycle as a fresh line change.

// File: rtl/lb_router_pkg.sv
package lb_router_pkg;

    typedef enum logic {
        LB_NORMAL = 1'b0,
        LB_LOOP   = 1'b1
    } lb_mode_e;

    localparam int MC_W    = 5;
    localparam int MC_DTR  = 0;
    localparam int MC_RTS  = 1;
    localparam int MC_OP1  = 2;
    localparam int MC_OP2  = 3;
    localparam int MC_LOOP = 4;

    localparam int MS_N   = 4;
    localparam int MS_CTS = 0;
    localparam int MS_DSR = 1;
    localparam int MS_RI  = 2;
    localparam int MS_CD  = 3;
    localparam int MSR_W  = 2 * MS_N;

endpackage

// File: rtl/lb_mode_fsm.sv
module lb_mode_fsm
    import lb_router_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic loop_req,
    output logic loop_on
);

    lb_mode_e state_q;
    lb_mode_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LB_NORMAL;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LB_NORMAL: if (loop_req)  state_d = LB_LOOP;   // enter_loop
            LB_LOOP:   if (!loop_req) state_d = LB_NORMAL; // leave_loop
            default:   state_d = LB_NORMAL;
        endcase
    end

    always_comb begin
        unique case (state_q)
            LB_LOOP: loop_on = 1'b1;
            default: loop_on = 1'b0;
        endcase
    end

endmodule

// File: rtl/lb_serial_route.sv
module lb_serial_route #(
    parameter logic IDLE_MARK = 1'b1,
    parameter logic LINE_OFF  = 1'b0
) (
    input  logic loop_on,
    input  logic tx_ser,
    input  logic rx_pin,
    input  logic dtr_ctl,
    input  logic rts_ctl,
    output logic tx_pin,
    output logic rx_ser,
    output logic dtr_pin,
    output logic rts_pin
);

    always_comb begin
        if (loop_on) begin
            tx_pin  = IDLE_MARK;
            rx_ser  = tx_ser;
            dtr_pin = LINE_OFF;
            rts_pin = LINE_OFF;
        end else begin
            tx_pin  = tx_ser;
            rx_ser  = rx_pin;
            dtr_pin = dtr_ctl;
            rts_pin = rts_ctl;
        end
    end

endmodule

// File: rtl/lb_modem_status.sv
module lb_modem_status #(
    parameter int N_LINES = 4,
    parameter int RI_POS  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 loop_on,
    input  logic [N_LINES-1:0]   ext_lines,
    input  logic [N_LINES-1:0]   loop_lines,
    input  logic                 rd_stb,
    output logic [2*N_LINES-1:0] status
);

    logic [N_LINES-1:0] src;
    logic [N_LINES-1:0] level_q;
    logic [N_LINES-1:0] flag_q;
    logic [N_LINES-1:0] hit;

    assign src = loop_on ? loop_lines : ext_lines;

    for (genvar i = 0; i < N_LINES; i++) begin : g_edge
        if (i == RI_POS) begin : g_trail
            assign hit[i] = level_q[i] & ~src[i];
        end else begin : g_any
            assign hit[i] = level_q[i] ^ src[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
            flag_q  <= '0;
        end else begin
            level_q <= src;
            flag_q  <= (rd_stb ? '0 : flag_q) | hit;
        end
    end

    assign status = {level_q, flag_q};

endmodule

// File: rtl/lpbk_modem_router.sv
module lpbk_modem_router
    import lb_router_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MC_W-1:0]  mcr_bits,
    input  logic             tx_ser_in,
    output logic             rx_ser_out,
    output logic             pin_tx,
    input  logic             pin_rx,
    input  logic             pin_cts,
    input  logic             pin_dsr,
    input  logic             pin_ri,
    input  logic             pin_cd,
    output logic             pin_rts,
    output logic             pin_dtr,
    input  logic             msr_rd,
    output logic [MSR_W-1:0] msr_q
);

    logic            loop_on;
    logic [MS_N-1:0] ext_lines;
    logic [MS_N-1:0] loop_lines;

    lb_mode_fsm u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .loop_req (mcr_bits[MC_LOOP]),
        .loop_on  (loop_on)
    );

    lb_serial_route u_route (
        .loop_on (loop_on),
        .tx_ser  (tx_ser_in),
        .rx_pin  (pin_rx),
        .dtr_ctl (mcr_bits[MC_DTR]),
        .rts_ctl (mcr_bits[MC_RTS]),
        .tx_pin  (pin_tx),
        .rx_ser  (rx_ser_out),
        .dtr_pin (pin_dtr),
        .rts_pin (pin_rts)
    );

    always_comb begin
        ext_lines          = '0;
        ext_lines[MS_CTS]  = pin_cts;
        ext_lines[MS_DSR]  = pin_dsr;
        ext_lines[MS_RI]   = pin_ri;
        ext_lines[MS_CD]   = pin_cd;
        loop_lines         = '0;
        loop_lines[MS_CTS] = mcr_bits[MC_RTS];
        loop_lines[MS_DSR] = mcr_bits[MC_DTR];
        loop_lines[MS_RI]  = mcr_bits[MC_OP1];
        loop_lines[MS_CD]  = mcr_bits[MC_OP2];
    end

    lb_modem_status #(
        .N_LINES (MS_N),
        .RI_POS  (MS_RI)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .loop_on    (loop_on),
        .ext_lines  (ext_lines),
        .loop_lines (loop_lines),
        .rd_stb     (msr_rd),
        .status     (msr_q)
    );

endmodule

// File: rtl/lpbk_modem_router_chk.sv
module lpbk_modem_router_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       loop_on,
    input logic [4:0] mcr_bits,
    input logic       pin_tx,
    input logic       pin_rts,
    input logic       pin_dtr,
    input logic       msr_rd,
    input logic [7:0] msr_q
);

    a_r4_mode_tracks_bit: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (loop_on == $past(mcr_bits[4])));

    a_r6_pins_quiet_in_loop: assert property (@(posedge clk) disable iff (!rst_n)
        loop_on |-> (pin_tx && !pin_rts && !pin_dtr));

    a_r8_loop_cross_map: assert property (@(posedge clk) disable iff (!rst_n)
        loop_on |=> (msr_q[7:4] == {$past(mcr_bits[3]), $past(mcr_bits[2]),
                                    $past(mcr_bits[0]), $past(mcr_bits[1])}));

    a_r9_ri_rise_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(msr_rd) && $rose(msr_q[6])) |-> !msr_q[2]);

    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(msr_rd) && $stable(msr_q[7:4])) |-> (msr_q[3:0] == 4'h0));

endmodule

bind lpbk_modem_router lpbk_modem_router_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .loop_on  (loop_on),
    .mcr_bits (mcr_bits),
    .pin_tx   (pin_tx),
    .pin_rts  (pin_rts),
    .pin_dtr  (pin_dtr),
    .msr_rd   (msr_rd),
    .msr_q    (msr_q)
);

// File: tb/lpbk_modem_router_tb_top.sv
`timescale 1ns/1ps
module lpbk_modem_router_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] mcr_bits = 5'd0;
    logic       tx_ser_in = 1'b1;
    logic       pin_rx = 1'b1;
    logic       pin_cts = 1'b0, pin_dsr = 1'b0, pin_ri = 1'b0, pin_cd = 1'b0;
    logic       msr_rd = 1'b0;
    logic       rx_ser_out, pin_tx, pin_rts, pin_dtr;
    logic [7:0] msr_q;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    string      q_tag[$];
    logic [11:0] q_exp[$];

    // reference model state
    logic       m_loop = 1'b0;
    logic [3:0] m_lvl = 4'h0;
    logic [3:0] m_flg = 4'h0;
    logic [4:0] p_ctl = 5'd0;
    logic       p_tx = 1'b1, p_rx = 1'b1, p_rd = 1'b0;
    logic [3:0] p_pins = 4'h0; // {cd, ri, dsr, cts}

    always #5 clk = ~clk;

    lpbk_modem_router dut_i (
        .clk(clk), .rst_n(rst_n), .mcr_bits(mcr_bits),
        .tx_ser_in(tx_ser_in), .rx_ser_out(rx_ser_out),
        .pin_tx(pin_tx), .pin_rx(pin_rx),
        .pin_cts(pin_cts), .pin_dsr(pin_dsr), .pin_ri(pin_ri), .pin_cd(pin_cd),
        .pin_rts(pin_rts), .pin_dtr(pin_dtr),
        .msr_rd(msr_rd), .msr_q(msr_q)
    );

    function automatic logic [11:0] expect_now();
        logic e_tx, e_rx, e_rts, e_dtr;
        e_tx  = m_loop ? 1'b1 : p_tx;
        e_rx  = m_loop ? p_tx : p_rx;
        e_rts = m_loop ? 1'b0 : p_ctl[1];
        e_dtr = m_loop ? 1'b0 : p_ctl[0];
        return {e_tx, e_rx, e_rts, e_dtr, m_lvl, m_flg};
    endfunction

    task automatic model_edge();
        logic [3:0] src;
        logic [3:0] hit;
        src = m_loop ? {p_ctl[3], p_ctl[2], p_ctl[0], p_ctl[1]} : p_pins;
        hit = (m_lvl ^ src) & 4'b1011;
        hit[2] = m_lvl[2] & ~src[2];
        m_flg = (p_rd ? 4'h0 : m_flg) | hit;
        m_lvl = src;
        m_loop = p_ctl[4];
    endtask

    // driver: advance model over the edge, apply new inputs, push expectation
    task automatic drive(input logic [4:0] ctl, input logic tx, input logic rx,
                         input logic [3:0] pins, input logic rd, input string tag);
        @(posedge clk);
        model_edge();
        #2;
        mcr_bits = ctl; tx_ser_in = tx; pin_rx = rx;
        {pin_cd, pin_ri, pin_dsr, pin_cts} = pins;
        msr_rd = rd;
        p_ctl = ctl; p_tx = tx; p_rx = rx; p_pins = pins; p_rd = rd;
        q_exp.push_back(expect_now());
        q_tag.push_back(tag);
    endtask

    // monitor: compare at the falling edge
    always @(negedge clk) begin
        while (q_exp.size() > 0) begin
            logic [11:0] e;
            string t;
            logic [11:0] act;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            act = {pin_tx, rx_ser_out, pin_rts, pin_dtr, msr_q};
            n_chk++;
            if (act !== e) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", t, act, e);
            end
        end
    end

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            report();
        end
    end

    initial begin
        #1;
        q_exp.push_back(12'hC00);
        q_tag.push_back("R1 reset state");
        #11 rst_n = 1'b1;

        drive(5'b00000, 1'b1, 1'b1, 4'h0, 1'b0, "R1 normal after reset");
        drive(5'b00011, 1'b0, 1'b1, 4'h0, 1'b0, "R2 R3 tx low, rts dtr high");
        drive(5'b00010, 1'b1, 1'b0, 4'h0, 1'b0, "R2 R3 rx low, dtr low");
        drive(5'b00001, 1'b0, 1'b0, 4'h1, 1'b0, "R3 R7 cts raised");
        drive(5'b00001, 1'b0, 1'b0, 4'h1, 1'b0, "R7 R9 cts level and flag");
        drive(5'b00001, 1'b1, 1'b1, 4'h1, 1'b1, "R10 read strobe");
        drive(5'b00001, 1'b1, 1'b1, 4'h1, 1'b0, "R10 flags cleared");
        drive(5'b00001, 1'b1, 1'b1, 4'h5, 1'b0, "R9 ri rises");
        drive(5'b00001, 1'b1, 1'b1, 4'h5, 1'b0, "R9 ri rise gives no flag");
        drive(5'b00001, 1'b1, 1'b1, 4'h1, 1'b0, "R9 ri falls");
        drive(5'b00001, 1'b1, 1'b1, 4'h1, 1'b0, "R9 trailing ri flag");
        drive(5'b00001, 1'b1, 1'b1, 4'hB, 1'b1, "R9 R10 dsr cd rise with read");
        drive(5'b00001, 1'b1, 1'b1, 4'hA, 1'b1, "R10 change during read sets");
        drive(5'b00001, 1'b1, 1'b1, 4'hA, 1'b0, "R10 only fresh flag kept");
        drive(5'b11010, 1'b0, 1'b1, 4'hA, 1'b1, "R4 loop request not yet active");
        drive(5'b11010, 1'b0, 1'b1, 4'hA, 1'b0, "R4 R5 R6 loop active");
        drive(5'b11010, 1'b1, 1'b0, 4'h5, 1'b0, "R5 R8 rx pin and modem pins ignored");
        drive(5'b11010, 1'b0, 1'b1, 4'h0, 1'b0, "R5 R8 loop map levels");
        drive(5'b10101, 1'b1, 1'b0, 4'hF, 1'b1, "R8 control bits swap");
        drive(5'b10001, 1'b0, 1'b0, 4'hF, 1'b0, "R8 R9 op1 drop gives ri flag");
        drive(5'b10001, 1'b1, 1'b1, 4'h0, 1'b1, "R6 R8 loop steady");
        drive(5'b00011, 1'b0, 1'b1, 4'h0, 1'b0, "R4 exit request still loop");
        drive(5'b00011, 1'b0, 1'b1, 4'h0, 1'b0, "R2 R3 R4 back to normal");
        drive(5'b00011, 1'b1, 1'b0, 4'h8, 1'b0, "R7 normal pins again");
        drive(5'b00000, 1'b1, 1'b1, 4'h8, 1'b0, "R7 R9 cd level seen");

        @(posedge clk);
        @(negedge clk);
        #1;
        finished = 1'b1;
        report();
    end

endmodule